// File: doc/BRIEF.md
# Weighted Pending-Channel Service Selector

This block decides which of a set of channels with outstanding events is served next. Each channel keeps a pending flag and a credit counter. When the block gets a request, it picks the pending channel that holds the most credit. A tie goes to the lowest channel number. The choice is reported as a registered valid flag and a channel number. The caller then does the service work outside this block. When that work is done, the caller pulses a done input. For receive-type channels, this takes one credit from the channel that was picked.

Once every pending channel has used up its credit, the next request refills all credit counters from a per-channel default-weight input. A round is the span during which at least one channel is pending. The number of selections in a round is capped. When the cap is reached, the block raises a yield flag and grants nothing more until the caller restarts the budget or the pending set drains to empty.

Top module: `credit_service_picker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block does the following at that edge: it clears every pending flag, clears the selection valid flag, clears the selection counter so `yield_o` is 0, and loads every credit counter from `dflt_wt_i`. Channel i owns bits [i*WW +: WW] of `dflt_wt_i`.
- R2: Pending flag i is set after a clock edge where `evt_i[i]`=1, and cleared after an edge where only `ack_i[i]`=1. When both are 1 at the same edge, the flag stays set. `pend_o` shows the flags.
- R3: A request (`req_i`=1 with `svc_i`=0 and `yield_o`=0) is accepted at a clock edge. From that edge, `sel_valid_o` shows whether an eligible channel existed. A channel is eligible only if it is pending and its credit is above zero. Flags and credits are sampled before that edge's own updates.
- R4: Among eligible channels, the one with the strictly largest credit is reported on `sel_chan_o`. When several channels tie on credit, the lowest index wins.
- R5: `svc_i`=1 while `sel_valid_o`=1 clears `sel_valid_o`. If the held channel is a receive channel (`RX_MASK` bit set; by default the even channels), its credit also drops by one, stopping at zero. Transmit channels keep their credit.
- R6: An accepted request with pending channels but no eligible one reloads every credit from `dflt_wt_i`, gives `sel_valid_o`=0, and does not count toward the budget.
- R7: Each granted selection adds one to the round's count. `yield_o` is 1 once the count equals `BUDGET` (default 100). While it is 1, requests grant nothing and reload nothing.
- R8: The round's count returns to zero at the edge after `pend_o` is all zeros, or at an edge where `resume_i`=1.
- R9: `svc_i` at the same edge as `req_i` blocks the request. `svc_i` while `sel_valid_o`=0 changes nothing.
- R10: A request while no channel is pending gives `sel_valid_o`=0 and changes no credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NCH | Per-channel event pulses that set pending |
| ack_i | input | NCH | Per-channel acknowledge that clears pending |
| req_i | input | 1 | Request for the next selection |
| svc_i | input | 1 | Service-done pulse for the held selection |
| resume_i | input | 1 | Restarts the selection budget |
| dflt_wt_i | input | NCH*WW | Per-channel default credits |
| pend_o | output | NCH | Pending flags |
| sel_valid_o | output | 1 | Held selection is valid |
| sel_chan_o | output | CHW | Held selected channel number |
| yield_o | output | 1 | Budget used up; the caller must reschedule |

## Verification
A wrong credit value does not show up at the ports right away. It shows up on a later request, as a different `sel_chan_o` or as an unexpected refill. That can be many grants after the fault. Checking the selection on every cycle against a reference model, over long random runs with service pulses mixed in, lets such faults surface. A bad budget counter shows up as `yield_o` rising too early or too late in the 100-plus grant run. A bad pending flag shows up on `pend_o` one cycle after the input that caused it.

// File: rtl/csp_pkg.sv
// Shared constants and action encoding for the credit service picker.
// Assumes nothing beyond IEEE 1800-2017.
package csp_pkg;
    localparam int unsigned CSP_NCH    = 20;
    localparam int unsigned CSP_WW     = 4;
    localparam int unsigned CSP_BUDGET = 100;

    // What the top-level controller does in a given cycle.
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PICK,
        ACT_RELOAD,
        ACT_SERVICE,
        ACT_HOLD
    } csp_act_e;
endpackage

// File: rtl/csp_pending.sv
// Pending-flag array: event pulses set a flag, acknowledges clear it.
// A set wins over a clear in the same cycle. Assumes a synchronous active-low reset.
module csp_pending #(
    parameter int unsigned NCH = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic [NCH-1:0] ack_i,
    output logic [NCH-1:0] pend_o
);
    logic [NCH-1:0] pend_q;

    // Update flags: clear the acknowledged ones, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_i) | evt_i;
    end

    assign pend_o = pend_q;

    // R2: an event always leaves its flag set
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(evt_i)) == $past(evt_i)));
    // R2: an acknowledge with no event clears the flag
    a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(ack_i & ~evt_i)) == '0));
endmodule

// File: rtl/csp_arbiter.sv
// Combinational credit arbiter: finds the pending channel with the strictly
// largest non-zero credit. A tie resolves to the lowest index.
// Assumes the credits arrive packed, with channel i in row i.
module csp_arbiter #(
    parameter int unsigned NCH = 20,
    parameter int unsigned WW  = 4,
    localparam int unsigned CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0]         pend_i,
    input  logic [NCH-1:0][WW-1:0] wt_i,
    output logic                   found_o,
    output logic [CHW-1:0]         best_o
);
    logic [WW-1:0] best_wt;

    // Linear scan: a strict greater-than keeps the earliest maximum.
    always_comb begin
        found_o = 1'b0;
        best_o  = '0;
        best_wt = '0;
        for (int i = 0; i < NCH; i++) begin
            if (pend_i[i] && (wt_i[i] > best_wt)) begin
                found_o = 1'b1;
                best_o  = CHW'(i);
                best_wt = wt_i[i];
            end
        end
    end

    // R3: a reported winner is pending and has credit
    always_comb begin
        if (found_o) begin
            a_r3_pick_eligible: assert (pend_i[best_o] && (wt_i[best_o] != '0));
        end
    end
endmodule

// File: rtl/csp_credit.sv
// Per-channel credit counters. A reload copies every default. A decrement
// hits one receive-type channel and stops at zero. Reset loads the defaults.
module csp_credit #(
    parameter int unsigned  NCH     = 20,
    parameter int unsigned  WW      = 4,
    parameter logic [NCH-1:0] RX_MASK = 20'h55555,
    localparam int unsigned CHW     = $clog2(NCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH*WW-1:0]      dflt_i,
    input  logic                   reload_i,
    input  logic                   dec_i,
    input  logic [CHW-1:0]         dec_ch_i,
    output logic [NCH-1:0][WW-1:0] wt_o
);
    logic [NCH-1:0][WW-1:0] wt_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // One counter per channel: a reset or reload loads it, a service on a receive channel takes one.
        always_ff @(posedge clk) begin
            if (!rst_n || reload_i)
                wt_q[g] <= dflt_i[g*WW +: WW];
            else if (dec_i && (dec_ch_i == CHW'(g)) && RX_MASK[g] && (wt_q[g] != '0))
                wt_q[g] <= wt_q[g] - 1'b1;
        end
    end

    assign wt_o = wt_q;

    // R6: a reload leaves every counter equal to its default
    a_r6_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (wt_q == $past(dflt_i)));
    // R5: servicing a transmit channel leaves all credit untouched
    a_r5_tx_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !reload_i && !RX_MASK[dec_ch_i]) |=> $stable(wt_q));
endmodule

// File: rtl/credit_service_picker.sv
// Top: ties the pending flags, credit counters and arbiter together. It holds
// the registered selection and enforces the per-round selection budget.
// Assumes svc_i refers to the selection currently held on the outputs.
module credit_service_picker
    import csp_pkg::*;
#(
    parameter int unsigned    NCH     = CSP_NCH,
    parameter int unsigned    WW      = CSP_WW,
    parameter int unsigned    BUDGET  = CSP_BUDGET,
    parameter logic [NCH-1:0] RX_MASK = 20'h55555,
    localparam int unsigned   CHW     = $clog2(NCH),
    localparam int unsigned   BW      = $clog2(BUDGET + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    evt_i,
    input  logic [NCH-1:0]    ack_i,
    input  logic              req_i,
    input  logic              svc_i,
    input  logic              resume_i,
    input  logic [NCH*WW-1:0] dflt_wt_i,
    output logic [NCH-1:0]    pend_o,
    output logic              sel_valid_o,
    output logic [CHW-1:0]    sel_chan_o,
    output logic              yield_o
);
    logic [NCH-1:0]         pend;
    logic [NCH-1:0][WW-1:0] wt;
    logic                   found;
    logic [CHW-1:0]         best;
    logic                   sel_v_q;
    logic [CHW-1:0]         sel_c_q;
    logic [BW-1:0]          cnt_q;
    logic                   spent;
    csp_act_e               act;

    csp_pending #(.NCH(NCH)) u_pend (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ack_i(ack_i), .pend_o(pend)
    );

    csp_arbiter #(.NCH(NCH), .WW(WW)) u_arb (
        .pend_i(pend), .wt_i(wt), .found_o(found), .best_o(best)
    );

    csp_credit #(.NCH(NCH), .WW(WW), .RX_MASK(RX_MASK)) u_cred (
        .clk(clk), .rst_n(rst_n), .dflt_i(dflt_wt_i),
        .reload_i(act == ACT_RELOAD),
        .dec_i(act == ACT_SERVICE), .dec_ch_i(sel_c_q),
        .wt_o(wt)
    );

    assign spent = (cnt_q == BW'(BUDGET));

    // Decode this cycle's action; a service pulse blocks any request.
    always_comb begin
        if (svc_i)
            act = sel_v_q ? ACT_SERVICE : ACT_IDLE;
        else if (!req_i)
            act = ACT_IDLE;
        else if (spent || (pend == '0))
            act = ACT_HOLD;
        else if (found)
            act = ACT_PICK;
        else
            act = ACT_RELOAD;
    end

    // Selection register: load on a grant, clear on service or a refused request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_v_q <= 1'b0;
            sel_c_q <= '0;
        end else begin
            case (act)
                ACT_PICK: begin
                    sel_v_q <= 1'b1;
                    sel_c_q <= best;
                end
                ACT_RELOAD, ACT_HOLD, ACT_SERVICE: sel_v_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // Round budget: counts grants, restarts on resume or an empty pending set.
    always_ff @(posedge clk) begin
        if (!rst_n || resume_i || (pend == '0)) cnt_q <= '0;
        else if (act == ACT_PICK)              cnt_q <= cnt_q + 1'b1;
    end

    assign pend_o      = pend;
    assign sel_valid_o = sel_v_q;
    assign sel_chan_o  = sel_c_q;
    assign yield_o     = spent;

    // R7: the grant count never passes the budget
    a_r7_budget_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BW'(BUDGET));
    // R7: no grant while the budget is spent
    a_r7_no_grant_spent: assert property (@(posedge clk) disable iff (!rst_n)
        (yield_o && req_i) |=> !sel_valid_o);
    // R5: a service pulse consumes the held selection
    a_r5_svc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_i && sel_valid_o) |=> !sel_valid_o);
    // R8: an empty pending set restarts the round
    a_r8_round_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o == '0) |=> !yield_o);
endmodule

// File: tb/credit_service_picker_tb.sv
module credit_service_picker_tb;
    localparam int NCH = 20;
    localparam int WW  = 4;
    localparam int BUDGET = 100;
    localparam logic [NCH-1:0] RXM = 20'h55555;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] evt = '0, ack = '0;
    logic req = 1'b0, svc = 1'b0, resume = 1'b0;
    logic [NCH*WW-1:0] dflt_bus;
    logic [NCH-1:0] pend_o;
    logic sel_valid_o;
    logic [4:0] sel_chan_o;
    logic yield_o;

    int total = 0;
    int bad = 0;

    // model state
    int dflt_m [NCH];
    int w_m [NCH];
    logic [NCH-1:0] pend_m;
    logic v_m;
    int c_m;
    int cnt_m;

    always #10 clk = ~clk;

    credit_service_picker u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .ack_i(ack), .req_i(req),
        .svc_i(svc), .resume_i(resume), .dflt_wt_i(dflt_bus), .pend_o(pend_o),
        .sel_valid_o(sel_valid_o), .sel_chan_o(sel_chan_o), .yield_o(yield_o)
    );

    always_comb begin
        for (int i = 0; i < NCH; i++) dflt_bus[i*WW +: WW] = WW'(dflt_m[i]);
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pick_best(output bit found);
        int bw = 0;
        int b = 0;
        found = 0;
        for (int i = 0; i < NCH; i++)
            if (pend_m[i] && w_m[i] > bw) begin
                bw = w_m[i]; b = i; found = 1;
            end
        return b;
    endfunction

    // Drive one cycle of inputs, advance the model, compare at the next falling edge.
    task automatic step(input logic [NCH-1:0] e, input logic [NCH-1:0] a,
                        input logic rq, input logic sv, input logic rs, input string tag);
        bit found;
        int b;
        bit spent, pick, reload, sact;
        evt = e; ack = a; req = rq; svc = sv; resume = rs;
        b = pick_best(found);
        spent = (cnt_m == BUDGET);
        sact = sv && v_m;
        pick = rq && !sv && !spent && (pend_m != 0) && found;
        reload = rq && !sv && !spent && (pend_m != 0) && !found;
        if (reload) begin
            for (int i = 0; i < NCH; i++) w_m[i] = dflt_m[i];
        end else if (sact && RXM[c_m] && w_m[c_m] > 0) begin
            w_m[c_m]--;
        end
        if (sv) begin
            if (v_m) v_m = 0;
        end else if (rq) begin
            v_m = pick;
            if (pick) c_m = b;
        end
        if (pend_m == 0 || rs) cnt_m = 0;
        else if (pick) cnt_m++;
        pend_m = (pend_m & ~a) | e;
        @(posedge clk);
        @(negedge clk);
        check({tag, " pend"}, int'(pend_o), int'(pend_m));
        check({tag, " valid"}, int'(sel_valid_o), int'(v_m));
        if (v_m) check({tag, " chan"}, int'(sel_chan_o), c_m);
        check({tag, " yield"}, int'(yield_o), int'(cnt_m == BUDGET));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        for (int i = 0; i < NCH; i++) dflt_m[i] = (i % 4) + 1;
        for (int i = 0; i < NCH; i++) w_m[i] = dflt_m[i];
        pend_m = '0; v_m = 0; c_m = 0; cnt_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 pend", int'(pend_o), 0);
        check("R1 valid", int'(sel_valid_o), 0);
        check("R1 yield", int'(yield_o), 0);

        // R2 set wins over clear, then a clear alone
        step(20'h00008, 20'h00008, 0, 0, 0, "R2 set+clear");
        check("R2 bit3 set", int'(pend_o[3]), 1);
        step(20'h0, 20'h00008, 0, 0, 0, "R2 clear");
        check("R2 bit3 clear", int'(pend_o[3]), 0);

        // R10 request with nothing pending
        step(20'h0, 20'h0, 1, 0, 0, "R10 empty req");
        check("R10 no grant", int'(sel_valid_o), 0);

        // R1/R4: defaults loaded by reset; channels 2,3,7 pending -> 3 (credit 4, lowest of tie with 7)
        step(20'h0008C, 20'h0, 0, 0, 0, "R2 set 2,3,7");
        step(20'h0, 20'h0, 1, 0, 0, "R4 tie");
        check("R4 tie lowest", int'(sel_chan_o), 3);
        // R5 transmit channel 3 keeps its credit
        step(20'h0, 20'h0, 0, 1, 0, "R5 tx svc");
        check("R5 consumed", int'(sel_valid_o), 0);
        step(20'h0, 20'h0, 1, 0, 0, "R5 tx again");
        check("R5 tx keeps credit", int'(sel_chan_o), 3);
        // R9 service together with a request blocks the request
        step(20'h0, 20'h0, 1, 1, 0, "R9 svc+req");
        check("R9 blocked", int'(sel_valid_o), 0);
        step(20'h0, 20'h0, 0, 1, 0, "R9 idle svc");

        // R5 receive: channels 2 and 6 (credit 3 each)
        step(20'h00044, 20'h0008C, 0, 0, 0, "R2 swap");
        step(20'h0, 20'h0, 1, 0, 0, "R4 rx pick");
        check("R4 rx first", int'(sel_chan_o), 2);
        step(20'h0, 20'h0, 0, 1, 0, "R5 rx svc");
        step(20'h0, 20'h0, 1, 0, 0, "R5 rx next");
        check("R5 rx decremented", int'(sel_chan_o), 6);

        // R6 drain credit on rx channel 0 only, then reload
        step(20'h00001, 20'h00044, 0, 0, 0, "R6 setup");
        step(20'h0, 20'h0, 1, 0, 0, "R6 pick0");
        step(20'h0, 20'h0, 0, 1, 0, "R6 svc0");
        step(20'h0, 20'h0, 1, 0, 0, "R6 reload");
        check("R6 no grant on reload", int'(sel_valid_o), 0);
        step(20'h0, 20'h0, 1, 0, 0, "R6 after reload");
        check("R6 refilled", int'(sel_chan_o), 0);

        // R7/R8 budget: keep channels 0 and 1 pending and grant repeatedly
        step(20'h00003, 20'h0, 0, 0, 1, "R8 resume");
        for (int k = 0; k < 130; k++) begin
            step(20'h0, 20'h0, 1, 0, 0, "R7 budget req");
            step(20'h0, 20'h0, 0, 1, 0, "R7 budget svc");
        end
        check("R7 yield high", int'(yield_o), 1);
        step(20'h0, 20'h0, 1, 0, 0, "R7 refused");
        check("R7 no grant", int'(sel_valid_o), 0);
        step(20'h0, 20'h0, 0, 0, 1, "R8 resume");
        check("R8 yield low", int'(yield_o), 0);
        step(20'h0, 20'hFFFFF, 0, 0, 0, "R8 drain");
        step(20'h0, 20'h0, 0, 0, 0, "R8 empty");

        // Random phase, with zero defaults on some channels
        dflt_m[5] = 0; dflt_m[10] = 0; dflt_m[13] = 7;
        for (int k = 0; k < 3000; k++) begin
            logic [NCH-1:0] e, a;
            logic rq, sv, rs;
            e = ($urandom % 4 == 0) ? NCH'(1 << ($urandom % NCH)) : '0;
            a = ($urandom % 6 == 0) ? NCH'(1 << ($urandom % NCH)) : '0;
            rq = ($urandom % 2) == 1;
            sv = ($urandom % 3) == 0;
            rs = ($urandom % 97) == 0;
            step(e, a, rq, sv, rs, "R3 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule